// File: doc/BRIEF.md
# Four-Bit Arithmetic Logic Slice with Group Carry Outputs

A purely combinational arithmetic logic unit built from four-bit slices. Each slice takes two four-bit operands, a four-bit function code and a mode bit. With the mode bit high, every result bit is a bitwise logic function of the two operands, one of sixteen. With the mode bit low, the internal carries run and the slice performs one of sixteen arithmetic functions. These include addition, subtraction, decrement, passing A through and doubling A.

Every slice reports a group generate and a group propagate. An external lookahead unit can use these to form all slice carries at once. The same slices can also be chained through their ripple carries. The top module does that chaining for a parameterised number of slices. It exposes the generate and propagate of every slice, and an all-ones flag on the result, which serves equality tests in subtract mode. Carry input, carry output, generate and propagate are all active low.

Top module: `alu_chain`

## Requirements
- R1: With `mode`=1 the result is a bitwise logic function chosen by `sel` (0 NOT A, 1 NOR, 2 NOT A AND B, 3 zero, 4 NAND, 5 NOT B, 6 XOR, 7 A AND NOT B, 8 NOT A OR B, 9 XNOR, 10 B, 11 AND, 12 all ones, 13 A OR NOT B, 14 OR, 15 A), and `carry_in_n` has no effect on it.
- R2: With `mode`=0 the result is X + Y + c modulo 2^W, where c = NOT `carry_in_n`, and (X,Y) by `sel` is: 0 (A,0), 1 (A|B,0), 2 (A|~B,0), 3 (ones,0), 4 (A,A&~B), 5 (A|B,A&~B), 6 (A,~B), 7 (A&~B,ones), 8 (A,A&B), 9 (A,B), 10 (A|~B,A&B), 11 (A&B,ones), 12 (A,A), 13 (A|B,A), 14 (A|~B,A), 15 (A,ones).
- R3: `sel`=9 with `mode`=0 adds A and B plus the carry; `sel`=6 with `mode`=0 gives A minus B minus 1 when `carry_in_n`=1 and A minus B when `carry_in_n`=0.
- R4: `carry_out_n` is low exactly when X + Y + c of R2 reaches 2^W, in both modes.
- R5: A slice's `gen_n` bit is low exactly when X + Y of its own nibble reaches 16.
- R6: When a slice's `gen_n` is high, its `prop_n` is low exactly when X + Y of its nibble equals 15.
- R7: `eq` is high exactly when every result bit is 1; with `mode`=0, `sel`=6, `carry_in_n`=1 it is high exactly when A equals B.
- R8: Slices ripple from least to most significant, and the carry formed by lookahead from all slice `gen_n`/`prop_n` bits and `carry_in_n` equals the final carry.
- R9: With `mode`=0 and `sel`=6, `carry_out_n` is low exactly when A > B if `carry_in_n`=1, and exactly when A >= B if `carry_in_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 4*NSLICE | Operand A |
| b | input | 4*NSLICE | Operand B |
| sel | input | 4 | Function code |
| mode | input | 1 | 1 selects logic functions, 0 arithmetic |
| carry_in_n | input | 1 | Carry into the least significant slice, active low |
| f | output | 4*NSLICE | Result |
| carry_out_n | output | 1 | Carry out of the most significant slice, active low |
| gen_n | output | NSLICE | Group generate of each slice, active low |
| prop_n | output | NSLICE | Group propagate of each slice, active low |
| eq | output | 1 | High when all result bits are 1 |

## Verification
The bench builds the block twice, with NSLICE=1 and NSLICE=2, and drives both from the same stimulus. The single slice is swept over every operand pair, all 32 functions and both carry inputs, so its nibble-level generate and propagate can be checked directly. The two-slice build brings the carry hand-off between slices into reach, together with the comparison of a lookahead carry formed from both slices' generate and propagate bits against the rippled carry. A short table of hand-worked eight-bit vectors covers additions that overflow, equal and ordered operands in subtract mode, and carry outputs in logic mode.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
    localparam int SLICE_W = 4;

    typedef logic [SLICE_W-1:0] nib_t;

    typedef struct packed {
        nib_t f;
        logic carry_out_n;
        logic gen_n;
        logic prop_n;
        logic eq;
    } slice_res_t;
endpackage

// File: rtl/alu4_bit_terms.sv
module alu4_bit_terms
    import alu4_pkg::*;
(
    input  nib_t       a,
    input  nib_t       b,
    input  logic [3:0] sel,
    output nib_t       prop,
    output nib_t       gen
);
    // Per-bit pass and generate terms; gen is always a subset of prop.
    for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
        assign prop[i] = a[i] | (b[i] & sel[0]) | (~b[i] & sel[1]);
        assign gen[i]  = (a[i] & ~b[i] & sel[2]) | (a[i] & b[i] & sel[3]);
    end
endmodule

// File: rtl/alu4_slice.sv
module alu4_slice
    import alu4_pkg::*;
(
    input  nib_t       a,
    input  nib_t       b,
    input  logic [3:0] sel,
    input  logic       mode,
    input  logic       carry_in_n,
    output nib_t       f,
    output logic       carry_out_n,
    output logic       gen_n,
    output logic       prop_n,
    output logic       eq
);
    nib_t       prop;
    nib_t       gen;
    slice_res_t res_d;

    alu4_bit_terms u_terms (
        .a    (a),
        .b    (b),
        .sel  (sel),
        .prop (prop),
        .gen  (gen)
    );

    always_comb begin
        logic [SLICE_W:0] cy;
        nib_t             half;
        logic             grp_gen;
        cy[0] = ~carry_in_n;
        for (int i = 0; i < SLICE_W; i++) begin
            cy[i+1] = gen[i] | (prop[i] & cy[i]);
        end
        grp_gen = 1'b0;
        for (int i = 0; i < SLICE_W; i++) begin
            grp_gen = gen[i] | (prop[i] & grp_gen);
        end
        half              = prop & ~gen;
        res_d.f           = mode ? ~half : (half ^ cy[SLICE_W-1:0]);
        res_d.carry_out_n = ~cy[SLICE_W];
        res_d.gen_n       = ~grp_gen;
        res_d.prop_n      = ~(&prop);
        res_d.eq          = &res_d.f;
    end

    assign f           = res_d.f;
    assign carry_out_n = res_d.carry_out_n;
    assign gen_n       = res_d.gen_n;
    assign prop_n      = res_d.prop_n;
    assign eq          = res_d.eq;
endmodule

// File: rtl/alu_chain.sv
module alu_chain
    import alu4_pkg::*;
#(
    parameter int NSLICE = 2
) (
    input  logic [NSLICE*SLICE_W-1:0] a,
    input  logic [NSLICE*SLICE_W-1:0] b,
    input  logic [3:0]                sel,
    input  logic                      mode,
    input  logic                      carry_in_n,
    output logic [NSLICE*SLICE_W-1:0] f,
    output logic                      carry_out_n,
    output logic [NSLICE-1:0]         gen_n,
    output logic [NSLICE-1:0]         prop_n,
    output logic                      eq
);
    localparam int W = NSLICE * SLICE_W;

    logic [NSLICE:0]   ripple_n;
    logic [NSLICE-1:0] slice_eq;

    assign ripple_n[0] = carry_in_n;

    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
        alu4_slice u_slice (
            .a           (a[k*SLICE_W +: SLICE_W]),
            .b           (b[k*SLICE_W +: SLICE_W]),
            .sel         (sel),
            .mode        (mode),
            .carry_in_n  (ripple_n[k]),
            .f           (f[k*SLICE_W +: SLICE_W]),
            .carry_out_n (ripple_n[k+1]),
            .gen_n       (gen_n[k]),
            .prop_n      (prop_n[k]),
            .eq          (slice_eq[k])
        );
    end

    assign carry_out_n = ripple_n[NSLICE];
    assign eq          = &slice_eq;

    if (W < SLICE_W) begin : g_bad_width
        initial $error("alu_chain needs at least one slice");
    end
endmodule

// File: rtl/alu_chain_chk.sv
module alu_chain_chk
    import alu4_pkg::*;
#(
    parameter int NSLICE = 2
) (
    input logic [NSLICE*SLICE_W-1:0] a,
    input logic [NSLICE*SLICE_W-1:0] b,
    input logic [3:0]                sel,
    input logic                      mode,
    input logic                      carry_in_n,
    input logic [NSLICE*SLICE_W-1:0] f,
    input logic                      carry_out_n,
    input logic [NSLICE-1:0]         gen_n,
    input logic [NSLICE-1:0]         prop_n,
    input logic                      eq,
    input logic [NSLICE:0]           ripple_n
);
    localparam int W = NSLICE * SLICE_W;

    logic [W:0] sum_ab;
    assign sum_ab = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ~carry_in_n};

    always_comb begin
        // R7: flag tracks an all-ones result
        p_eq_ones_r7: assert (eq == (&f))
            else $error("eq disagrees with result bits");
        // R3: addition with carry
        if (!mode && sel == 4'b1001) begin
            p_add_r3: assert ({~carry_out_n, f} == sum_ab)
                else $error("add result wrong");
        end
        // R1: logic XOR
        if (mode && sel == 4'b0110) begin
            p_xor_r1: assert (f == (a ^ b))
                else $error("xor result wrong");
        end
        // R9: magnitude compare through carry out
        if (!mode && sel == 4'b0110 && carry_in_n) begin
            p_greater_r9: assert (carry_out_n == !(a > b))
                else $error("greater-than carry wrong");
            p_equal_r7: assert (eq == (a == b))
                else $error("equality flag wrong");
        end
        // R8: each slice carry agrees with its generate/propagate
        for (int k = 0; k < NSLICE; k++) begin
            p_lookahead_r8: assert (ripple_n[k+1] == (gen_n[k] & (prop_n[k] | ripple_n[k])))
                else $error("slice carry disagrees with lookahead terms");
        end
    end
endmodule

bind alu_chain alu_chain_chk #(.NSLICE(NSLICE)) u_chk (
    .a           (a),
    .b           (b),
    .sel         (sel),
    .mode        (mode),
    .carry_in_n  (carry_in_n),
    .f           (f),
    .carry_out_n (carry_out_n),
    .gen_n       (gen_n),
    .prop_n      (prop_n),
    .eq          (eq),
    .ripple_n    (ripple_n)
);

// File: tb/tb_alu_chain.sv
module tb_alu_chain;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [7:0] a8, b8;
    logic [3:0] sel;
    logic       mode, cin_n;

    logic [7:0] f8;
    logic       co8, eq8;
    logic [1:0] g8, p8;
    logic [3:0] f4;
    logic       co4, eq4;
    logic [0:0] g4, p4;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    alu_chain #(.NSLICE(2)) dut (
        .a(a8), .b(b8), .sel(sel), .mode(mode), .carry_in_n(cin_n),
        .f(f8), .carry_out_n(co8), .gen_n(g8), .prop_n(p8), .eq(eq8)
    );

    alu_chain #(.NSLICE(1)) dut_one (
        .a(a8[3:0]), .b(b8[3:0]), .sel(sel), .mode(mode), .carry_in_n(cin_n),
        .f(f4), .carry_out_n(co4), .gen_n(g4), .prop_n(p4), .eq(eq4)
    );

    typedef struct packed {
        logic       m;
        logic [3:0] s;
        logic       cn;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] f;
        logic       co_n;
        logic       eq;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 4'd9,  1'b1, 8'h3C, 8'h45, 8'h81, 1'b1, 1'b0},
        '{1'b0, 4'd9,  1'b0, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0},
        '{1'b0, 4'd6,  1'b1, 8'h55, 8'h55, 8'hFF, 1'b1, 1'b1},
        '{1'b0, 4'd6,  1'b0, 8'h80, 8'h01, 8'h7F, 1'b0, 1'b0},
        '{1'b0, 4'd6,  1'b1, 8'h10, 8'h20, 8'hEF, 1'b1, 1'b0},
        '{1'b0, 4'd12, 1'b1, 8'hC3, 8'h00, 8'h86, 1'b0, 1'b0},
        '{1'b0, 4'd15, 1'b1, 8'h00, 8'h5A, 8'hFF, 1'b1, 1'b1},
        '{1'b0, 4'd0,  1'b0, 8'hFF, 8'h12, 8'h00, 1'b0, 1'b0},
        '{1'b1, 4'd6,  1'b1, 8'hF0, 8'h3C, 8'hCC, 1'b0, 1'b0},
        '{1'b1, 4'd11, 1'b0, 8'hF0, 8'h3C, 8'h30, 1'b0, 1'b0},
        '{1'b1, 4'd12, 1'b1, 8'h12, 8'h34, 8'hFF, 1'b1, 1'b1},
        '{1'b1, 4'd3,  1'b1, 8'hAB, 8'hCD, 8'h00, 1'b1, 1'b0},
        '{1'b1, 4'd1,  1'b1, 8'h0F, 8'h30, 8'hC0, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: mode=%0b sel=%0d cin_n=%0b a=%h b=%h actual %h expected %h",
                     tag, mode, sel, cin_n, a8, b8, act, exp);
        end
    endtask

    function automatic string tag_of(input logic m, input logic [3:0] s);
        if (m) return "R1";
        if (s == 4'd9 || s == 4'd6) return "R3";
        return "R2";
    endfunction

    // Operand pair (X,Y) of the arithmetic table, width w
    function automatic void arith_pair(input int w, input logic [3:0] s,
                                       input int av, input int bv,
                                       output int x, output int y);
        int m  = (1 << w) - 1;
        int nb = ~bv & m;
        case (s)
            4'd0:  begin x = av;        y = 0;         end
            4'd1:  begin x = av | bv;   y = 0;         end
            4'd2:  begin x = av | nb;   y = 0;         end
            4'd3:  begin x = m;         y = 0;         end
            4'd4:  begin x = av;        y = av & nb;   end
            4'd5:  begin x = av | bv;   y = av & nb;   end
            4'd6:  begin x = av;        y = nb;        end
            4'd7:  begin x = av & nb;   y = m;         end
            4'd8:  begin x = av;        y = av & bv;   end
            4'd9:  begin x = av;        y = bv;        end
            4'd10: begin x = av | nb;   y = av & bv;   end
            4'd11: begin x = av & bv;   y = m;         end
            4'd12: begin x = av;        y = av;        end
            4'd13: begin x = av | bv;   y = av;        end
            4'd14: begin x = av | nb;   y = av;        end
            default: begin x = av;      y = m;         end
        endcase
    endfunction

    function automatic int logic_ref(input int w, input logic [3:0] s, input int av, input int bv);
        int m = (1 << w) - 1;
        int r;
        case (s)
            4'd0:  r = ~av;
            4'd1:  r = ~(av | bv);
            4'd2:  r = ~av & bv;
            4'd3:  r = 0;
            4'd4:  r = ~(av & bv);
            4'd5:  r = ~bv;
            4'd6:  r = av ^ bv;
            4'd7:  r = av & ~bv;
            4'd8:  r = ~av | bv;
            4'd9:  r = ~(av ^ bv);
            4'd10: r = bv;
            4'd11: r = av & bv;
            4'd12: r = m;
            4'd13: r = av | ~bv;
            4'd14: r = av | bv;
            default: r = av;
        endcase
        return r & m;
    endfunction

    task automatic apply(input logic m, input logic [3:0] s, input logic cn,
                         input logic [7:0] av, input logic [7:0] bv);
        @(posedge clk);
        #1;
        mode = m; sel = s; cin_n = cn; a8 = av; b8 = bv;
        @(negedge clk);
    endtask

    // Full reference comparison of both builds for the current inputs
    task automatic check_all();
        int x, y, sum, ef, c, ac;
        string t = tag_of(mode, sel);
        // eight-bit build
        arith_pair(8, sel, int'(a8), int'(b8), x, y);
        sum = x + y + (cin_n ? 0 : 1);
        ef  = mode ? logic_ref(8, sel, int'(a8), int'(b8)) : (sum & 8'hFF);
        chk(t, f8, 8'(ef));
        chk("R4", {7'd0, co8}, {7'd0, ~sum[8]});
        chk("R7", {7'd0, eq8}, {7'd0, (ef == 255)});
        c = cin_n ? 0 : 1;
        for (int k = 0; k < 2; k++) begin
            c = (!g8[k] || (!p8[k] && c != 0)) ? 1 : 0;
        end
        chk("R8", 8'(c), {7'd0, sum[8]});
        if (!mode && sel == 4'd6) begin
            ac = cin_n ? ((a8 > b8) ? 1 : 0) : ((a8 >= b8) ? 1 : 0);
            chk("R9", {7'd0, ~co8}, 8'(ac));
        end
        // four-bit build
        arith_pair(4, sel, int'(a8[3:0]), int'(b8[3:0]), x, y);
        sum = x + y + (cin_n ? 0 : 1);
        ef  = mode ? logic_ref(4, sel, int'(a8[3:0]), int'(b8[3:0])) : (sum & 4'hF);
        chk(t, {4'd0, f4}, 8'(ef));
        chk("R4", {7'd0, co4}, {7'd0, ~sum[4]});
        chk("R7", {7'd0, eq4}, {7'd0, (ef == 15)});
        chk("R5", {7'd0, g4[0]}, {7'd0, !((x + y) >= 16)});
        if (g4[0]) chk("R6", {7'd0, p4[0]}, {7'd0, !((x + y) == 15)});
    endtask

    initial begin : watchdog
        for (int i = 0; i < 60000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        a8 = '0; b8 = '0; sel = '0; mode = 1'b0; cin_n = 1'b1;

        // Directed vector table on the eight-bit build (R1 R3 R4 R7 R9)
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i].m, VEC[i].s, VEC[i].cn, VEC[i].a, VEC[i].b);
            chk(tag_of(VEC[i].m, VEC[i].s), f8, VEC[i].f);
            chk("R4", {7'd0, co8}, {7'd0, VEC[i].co_n});
            chk("R7", {7'd0, eq8}, {7'd0, VEC[i].eq});
        end

        // Every function, both carries, every low-nibble pair; the upper
        // nibble varies with the stimulus to reach inter-slice carries (R8)
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 16; s++) begin
                for (int cn = 0; cn < 2; cn++) begin
                    for (int ab = 0; ab < 256; ab++) begin
                        logic [3:0] lo_a = 4'(ab >> 4);
                        logic [3:0] lo_b = 4'(ab);
                        logic [3:0] hi_a = 4'(ab * 7 + s);
                        logic [3:0] hi_b = 4'(ab * 5 + 3 * s + cn);
                        apply(1'(m), 4'(s), 1'(cn), {hi_a, lo_a}, {hi_b, lo_b});
                        check_all();
                    end
                end
            end
        end

        // Corner: logic mode ignores the carry input (R1)
        apply(1'b1, 4'd9, 1'b0, 8'hA5, 8'h5A);
        chk("R1", f8, 8'h00);
        apply(1'b1, 4'd9, 1'b1, 8'hA5, 8'h5A);
        chk("R1", f8, 8'h00);

        // Corner: carry must cross the slice boundary (R8)
        apply(1'b0, 4'd9, 1'b0, 8'h0F, 8'h00);
        chk("R8", f8, 8'h10);
        chk("R4", {7'd0, co8}, 8'h01);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule